// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Register Slave

This block is a receive-only slave on a two-wire serial bus (I2C standard mode). It samples SCL and SDA with a fast system clock and passes both through synchronizers. It recognises bus start and stop conditions, then checks the first byte of each transfer against a fixed device address. Each data byte that follows is written into a bank of byte-wide configuration registers. Every bit of the bank drives one output-enable line of the surrounding logic.

The block keeps no register pointer and cannot be read. Each transfer fills the bank from register 0 upward, one register per byte. To change a later register, the bus master must resend every register below it. The block acknowledges each accepted byte by driving its open-drain pull-low output. It stores at most `NUM_REGS` data bytes per transfer.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset every bit of `cfg_o` is 1 and `sda_pull_o` is 0.
- R2: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. Bits clocked without a preceding start are never acknowledged.
- R3: The address byte 0xD2 (7-bit address 0x69 in bits 7:1, bit 0 = 0 for write) is acknowledged: `sda_pull_o` is 1 while SCL is high during the ninth clock of that byte.
- R4: Any other address byte, including 0xD3 (bit 0 = 1, read), is not acknowledged. No later byte is acknowledged or stored until the next start.
- R5: Data bits arrive most significant bit first. The k-th data byte after the address (k counting from 0) is written to `cfg_o[8k+7:8k]` and acknowledged.
- R6: Data bytes beyond `NUM_REGS` (10) in one transfer are not acknowledged and change no register.
- R7: A repeated start or a stop resets the byte position to register 0. Registers already written keep their values.
- R8: `sda_pull_o` changes only while the synchronized SCL is low, and it is 0 after a stop.
- R9: A register that a transfer does not reach keeps its previous value. Registers change only when a data byte completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| cfg_o | output | 8*NUM_REGS | Configuration register bank, register k in bits 8k+7:8k |

## Verification
The assertions assume that each SCL low phase lasts at least two system clocks. They also assume that the master never creates a start or stop while the slave holds SDA low, which the wired-AND bus makes impossible anyway. The bench drives each bus phase for five system clocks and models SDA as the AND of the master's drive and the slave's release. Under those conditions, changes of the pull output and of the register bank always fall in SCL-low windows. The sweeps cover every address with both R/W values and transfer lengths from zero to past the byte limit.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_IGNORE
  } ctrl_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff   <= {sda_ff[STAGES-2:0], sda_i};
      scl_prev <= scl_ff[STAGES-1];
      sda_prev <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  // SCL must be high on both samples so a clock edge is never taken as a condition
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              sda_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      byte_o <= '0;
    end else if (clear_i) begin
      cnt_q  <= '0;
    end else if (sample_i && !full_o) begin
      cnt_q  <= cnt_q + 1'b1;
      byte_o <= {byte_o[BYTE_W-2:0], sda_i};
    end
  end

  assign full_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/i2c_ctrl.sv
module i2c_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter int          NUM_REGS = 10,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int          IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       byte_i,
  input  logic             full_i,
  output logic             shift_en_o,
  output logic             shift_clr_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             pull_o,
  output ctrl_state_e      state_o
);
  localparam logic [7:0]       ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [IDX_W-1:0] IDX_LIM   = IDX_W'(NUM_REGS);

  ctrl_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             ack_q;
  logic             byte_end;
  logic             room;

  assign byte_end = full_i & scl_fall_i;
  assign room     = (idx_q < IDX_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ack_q   <= 1'b0;
    end else if (start_i) begin
      state_q <= ST_ADDR;
      idx_q   <= '0;
      ack_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (byte_end) begin
          ack_q   <= (byte_i == ADDR_BYTE);
          state_q <= ST_ADDR_ACK;
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          state_q <= ack_q ? ST_DATA : ST_IGNORE;
          ack_q   <= 1'b0;
        end
        ST_DATA: if (byte_end) begin
          ack_q   <= room;
          if (room) idx_q <= idx_q + 1'b1;
          state_q <= ST_DATA_ACK;
        end
        ST_DATA_ACK: if (scl_fall_i) begin
          state_q <= ST_DATA;
          ack_q   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign shift_en_o  = scl_rise_i & ((state_q == ST_ADDR) | (state_q == ST_DATA));
  assign shift_clr_o = start_i | stop_i | byte_end;
  assign wr_en_o     = (state_q == ST_DATA) & byte_end & room & ~start_i & ~stop_i;
  assign wr_idx_o    = idx_q;
  assign pull_o      = ack_q & ((state_q == ST_ADDR_ACK) | (state_q == ST_DATA_ACK));
  assign state_o     = state_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int NUM_REGS = 10,
  parameter int REG_W    = 8,
  parameter int IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [REG_W-1:0]          wr_data_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g*REG_W +: REG_W] <= '1;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        regs_o[g*REG_W +: REG_W] <= wr_data_i;
    end
  end
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 10,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [8*NUM_REGS-1:0] cfg_o
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic shift_en, shift_clr, byte_full, wr_en;
  logic [7:0] rx_byte;
  logic [IDX_W-1:0] wr_idx;
  ctrl_state_e ctrl_state;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_byte_shift #(.BYTE_W(8)) u_shift (
    .clk_i, .rst_ni,
    .clear_i(shift_clr), .sample_i(shift_en), .sda_i(sda_s),
    .byte_o(rx_byte), .full_o(byte_full)
  );

  i2c_ctrl #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .byte_i(rx_byte), .full_i(byte_full),
    .shift_en_o(shift_en), .shift_clr_o(shift_clr),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .pull_o(sda_pull_o), .state_o(ctrl_state)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(8), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(rx_byte),
    .regs_o(cfg_o)
  );
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS = 10,
  parameter int IDX_W    = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input ctrl_state_e           ctrl_state,
  input logic                  sda_pull_o,
  input logic [8*NUM_REGS-1:0] cfg_o
);
  assert_pull_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pull_o) |-> !scl_s);

  assert_stop_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o);

  assert_ignore_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_state == ST_IGNORE) |-> !sda_pull_o);

  assert_wr_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));

  assert_cfg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(cfg_o));

  assert_write_scl_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !scl_s);
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .stop_det(stop_det),
  .wr_en(wr_en), .wr_idx(wr_idx), .ctrl_state(ctrl_state),
  .sda_pull_o(sda_pull_o), .cfg_o(cfg_o)
);

// File: tb/i2c_cfg_slave_tb.sv
module i2c_cfg_slave_tb;
  localparam int NREG = 10;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic sda_pull;
  logic [8*NREG-1:0] cfg;
  logic sda_bus;
  logic ack;
  logic [7:0] model [NREG];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign sda_bus = sda_drv & ~sda_pull;

  i2c_cfg_slave #(.NUM_REGS(NREG)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_drv), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq();
    scl_drv = 1'b1; wq();
    sda_drv = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wq();
      scl_drv = 1'b1; wq(); wq();
      scl_drv = 1'b0;
    end
    wq();
    sda_drv = 1'b1; wq();
    scl_drv = 1'b1; wq();
    a = ~sda_bus;
    wq();
    scl_drv = 1'b0; wq();
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(cfg[8*i +: 8] == model[i], req, int'(cfg[8*i +: 8]), int'(model[i]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset values
    check_bank("R1");
    chk(sda_pull == 1'b0, "R1", int'(sda_pull), 0);

    // R5 R6 R9: length sweep, 0..12 data bytes per transfer
    for (int n = 0; n <= NREG + 2; n++) begin
      bus_start();
      send_byte(8'hD2, ack);
      chk(ack == 1'b1, "R3", int'(ack), 1);
      for (int i = 0; i < n; i++) begin
        logic [7:0] v;
        v = 8'((n * 37 + i * 11 + 5) & 255);
        send_byte(v, ack);
        if (i < NREG) begin
          model[i] = v;
          chk(ack == 1'b1, "R5", int'(ack), 1);
        end else begin
          chk(ack == 1'b0, "R6", int'(ack), 0);
        end
      end
      bus_stop();
      wq();
      chk(sda_pull == 1'b0, "R8", int'(sda_pull), 0);
      check_bank("R5_R6_R9");
    end

    // R3 R4: every 7-bit address with both R/W values
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        logic exp_ack;
        logic [7:0] d;
        exp_ack = (a == 'h69) && (rw == 0);
        d = 8'((a * 3 + rw * 101 + 17) & 255);
        bus_start();
        send_byte({7'(a), 1'(rw)}, ack);
        chk(ack == exp_ack, exp_ack ? "R3" : "R4", int'(ack), int'(exp_ack));
        send_byte(d, ack);
        chk(ack == exp_ack, "R4", int'(ack), int'(exp_ack));
        if (exp_ack) model[0] = d;
        bus_stop();
        wq();
        chk(cfg[7:0] == model[0], "R4", int'(cfg[7:0]), int'(model[0]));
      end
    end
    check_bank("R4");

    // R7: repeated start restarts at register 0, earlier writes kept
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'hA5, ack); model[0] = 8'hA5;
    send_byte(8'h3C, ack); model[1] = 8'h3C;
    bus_start();
    send_byte(8'hD2, ack);
    chk(ack == 1'b1, "R7", int'(ack), 1);
    send_byte(8'h81, ack); model[0] = 8'h81;
    bus_stop();
    wq();
    check_bank("R7");

    // R2: bits clocked with no start are ignored
    send_byte(8'hD2, ack);
    chk(ack == 1'b0, "R2", int'(ack), 0);
    send_byte(8'h00, ack);
    chk(ack == 1'b0, "R2", int'(ack), 0);
    bus_stop();
    wq();
    check_bank("R2");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule